// File: doc/BRIEF.md
# Three-Channel Buffered PWM Timer

This block is an up-counting PWM timer with one shared period and three duty channels. Four compare slots are held in a register bank. Slot 0 sets the period, and slots 1 to 3 set the active width of pins 1 to 3. While the timer runs, a write lands in a holding register. It reaches the working copy only when the counter wraps. A duty or period change therefore never cuts a period short and never stretches one.

The counter can advance on a count-enable strobe from an upstream divider. It can instead advance on rising edges of an asynchronous event input. The block raises one interrupt pulse when the period wraps and one interrupt pulse per channel on a compare match. Counting happens only while the run bit is set and the mode field selects PWM.

Top module: `pwm3_timer`

## Requirements
- R1: After reset, every PWM output and every interrupt output is 0.
- R2: Counting starts at a rising edge of run enable while the mode field is 3'b100. On the clock edge after run_i rises, the counter is loaded with 0 and no interrupt is raised. The counter reset value is all ones.
- R3: While running, each count step adds one to the counter. A step that finds the counter equal to the working period value loads 0 instead. One period therefore lasts (period + 1) count steps.
- R4: Output k (pwm_o[k-1], k = 1..3) is 1 while the counter is less than the working compare value k, and 0 otherwise. A value of 0 keeps the output low. A value greater than the period keeps the output high.
- R5: wr_idx_i selects the slot: 0 is the period, and 1 to 3 are the channel compare values. A write made while running changes only the holding register. All working copies are loaded from the holding registers at the step that wraps the counter to 0.
- R6: A write made while the timer is stopped goes to both the holding register and the working copy, so the first period uses it.
- R7: irq_o[0] pulses for one clock cycle, in the cycle after a step that wrapped the counter to 0.
- R8: irq_o[k] pulses in the cycle after a count step whose new counter value equals working compare value k.
- R9: When ext_sel_i is 0, a count step occurs on each clock with cnt_tick_i high. When ext_sel_i is 1, cnt_tick_i has no effect and a step occurs once per rising edge of evt_i. The step reaches the counter on the third clock edge after evt_i goes high, after two synchronizer flops and an edge detect.
- R10: A mode value other than 3'b100 acts as stopped, even when run_i is 1.
- R11: From the clock edge after run_i falls, the outputs are 0, the interrupts stay 0, and count strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run enable |
| mode_i | input | 3 | Timer mode; 3'b100 selects PWM |
| ext_sel_i | input | 1 | Count source: 0 strobe, 1 event input |
| cnt_tick_i | input | 1 | Count-enable strobe |
| evt_i | input | 1 | Asynchronous external event |
| wr_en_i | input | 1 | Compare write strobe |
| wr_idx_i | input | 2 | Compare slot, 0 period, 1..3 channels |
| wr_data_i | input | 16 | Compare write data |
| pwm_o | output | 3 | PWM outputs, bit k-1 is channel k |
| irq_o | output | 4 | Bit 0 period wrap, bits 1..3 channel match |

## Verification
The hardest case to reach is a write made while the timer is running. The new value must stay invisible until the wrap and then apply to every channel at once. The bench stops the count strobe, rewrites the period and one duty value mid-period, and resumes counting. Its own model holds separate holding and working copies, so any early or late load shows up on the pins. The event path is driven with the internal strobe held high. This proves the strobe is ignored and that the step lands exactly three clock edges after the event rises.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam logic [2:0] MODE_PWM = 3'b100;
  typedef enum logic {SRC_STROBE = 1'b0, SRC_EVENT = 1'b1} cnt_src_e;
endpackage

// File: rtl/pwm3_evt_sync.sv
module pwm3_evt_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic rise_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], evt_i};
  end

  // sh_q[1] is the synchronized level, sh_q[2] its previous value
  assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/pwm3_cmp_bank.sv
module pwm3_cmp_bank #(
  parameter int CNT_W = 16,
  parameter int N_CMP = 4,
  localparam int IDX_W = $clog2(N_CMP)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         run_q_i,
  input  logic                         load_i,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [CNT_W-1:0]             wr_data_i,
  output logic [N_CMP-1:0][CNT_W-1:0]  work_o
);
  logic [N_CMP-1:0][CNT_W-1:0] hold_q;

  for (genvar i = 0; i < N_CMP; i++) begin : g_slot
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  hold_q[i] <= '0;
      else if (hit) hold_q[i] <= wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              work_o[i] <= '0;
      else if (!run_q_i && hit) work_o[i] <= wr_data_i;
      else if (load_i)          work_o[i] <= hold_q[i];
    end
  end
endmodule

// File: rtl/pwm3_counter.sv
module pwm3_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             wrap_o,
  output logic             step_q_o,
  output logic             wrap_q_o
);
  logic start, step;

  assign start  = active_i & ~run_o;
  assign step   = active_i & run_o & tick_i;
  assign wrap_o = step && (cnt_o == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '1;
      run_o    <= 1'b0;
      step_q_o <= 1'b0;
      wrap_q_o <= 1'b0;
    end else begin
      run_o    <= active_i;
      step_q_o <= step;
      wrap_q_o <= wrap_o;
      if (start)       cnt_o <= '0;
      else if (wrap_o) cnt_o <= '0;
      else if (step)   cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer #(
  parameter int CNT_W = 16,
  parameter int N_CH  = 3,
  localparam int N_CMP = N_CH + 1,
  localparam int IDX_W = $clog2(N_CMP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [2:0]       mode_i,
  input  logic             ext_sel_i,
  input  logic             cnt_tick_i,
  input  logic             evt_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [N_CH-1:0]  pwm_o,
  output logic [N_CMP-1:0] irq_o
);
  import pwm3_pkg::*;

  logic                        evt_rise, tick, active;
  logic                        run_q, wrap, step_q, wrap_q;
  logic [CNT_W-1:0]            cnt_q;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_work;

  assign active = run_i && (mode_i == MODE_PWM);
  assign tick   = (cnt_src_e'(ext_sel_i) == SRC_EVENT) ? evt_rise : cnt_tick_i;

  pwm3_evt_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .rise_o (evt_rise)
  );

  pwm3_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .tick_i   (tick),
    .period_i (cmp_work[0]),
    .cnt_o    (cnt_q),
    .run_o    (run_q),
    .wrap_o   (wrap),
    .step_q_o (step_q),
    .wrap_q_o (wrap_q)
  );

  pwm3_cmp_bank #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_q_i   (run_q),
    .load_i    (wrap),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .work_o    (cmp_work)
  );

  assign irq_o[0] = wrap_q;

  for (genvar k = 1; k < N_CMP; k++) begin : g_ch
    assign pwm_o[k-1] = run_q && (cnt_q < cmp_work[k]);
    assign irq_o[k]   = step_q && (cnt_q == cmp_work[k]);
  end
endmodule

// File: rtl/pwm3_timer_chk.sv
module pwm3_timer_chk #(
  parameter int CNT_W = 16,
  parameter int N_CMP = 4
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        run_q,
  input logic [CNT_W-1:0]            cnt,
  input logic [N_CMP-1:0][CNT_W-1:0] work,
  input logic [N_CMP-2:0]            pwm_o,
  input logic [N_CMP-1:0]            irq_o
);
  p_start_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> cnt == '0);

  p_cnt_in_period_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt <= work[0]);

  p_work_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt != '0) |-> $stable(work));

  p_wrap_irq_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[0] |-> cnt == '0);

  p_stopped_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (pwm_o == '0 && irq_o == '0));
endmodule

bind pwm3_timer pwm3_timer_chk #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .run_q  (run_q),
  .cnt    (cnt_q),
  .work   (cmp_work),
  .pwm_o  (pwm_o),
  .irq_o  (irq_o)
);

// File: tb/pwm3_timer_bench.sv
module pwm3_timer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic [2:0]  mode_i = 3'b100;
  logic        ext_sel_i = 1'b0;
  logic        cnt_tick_i = 1'b0;
  logic        evt_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_idx_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [2:0]  pwm_o;
  logic [3:0]  irq_o;

  always #4 clk_i = ~clk_i;

  pwm3_timer u_pwm3_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .mode_i(mode_i),
    .ext_sel_i(ext_sel_i), .cnt_tick_i(cnt_tick_i), .evt_i(evt_i),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );

  // period, ch1, ch2, ch3
  localparam int VEC [5][4] = '{
    '{5, 2, 0, 7}, '{3, 1, 3, 4}, '{7, 4, 6, 8}, '{0, 1, 0, 0}, '{2, 3, 1, 2}
  };

  int n_chk = 0, n_bad = 0;
  int m_cnt = 0;
  int m_hold [4] = '{0, 0, 0, 0};
  int m_work [4] = '{0, 0, 0, 0};
  bit m_run = 0, m_step = 0, m_wrap = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    logic [2:0] ep;
    logic [3:0] ei;
    ei[0] = m_wrap;
    for (int k = 1; k < 4; k++) begin
      ep[k-1] = m_run && (m_cnt < m_work[k]);
      ei[k]   = m_step && (m_cnt == m_work[k]);
    end
    chk({req, " pwm"}, 32'(pwm_o), 32'(ep));
    chk({req, " irq"}, 32'(irq_o), 32'(ei));
  endtask

  task automatic wr(int idx, int data);
    wr_en_i = 1'b1; wr_idx_i = 2'(idx); wr_data_i = 16'(data);
    @(posedge clk_i);
    m_hold[idx] = data;
    if (!m_run) m_work[idx] = data;
    m_step = 0; m_wrap = 0;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic step_n(string req, int n);
    cnt_tick_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      if (m_run) begin
        m_step = 1;
        m_wrap = (m_cnt == m_work[0]);
        if (m_wrap) begin
          m_cnt = 0;
          for (int j = 0; j < 4; j++) m_work[j] = m_hold[j];
        end else m_cnt++;
      end else begin
        m_step = 0; m_wrap = 0;
      end
      @(negedge clk_i);
      check_outs(req);
    end
    cnt_tick_i = 1'b0;
  endtask

  task automatic start_run();
    run_i = 1'b1;
    @(posedge clk_i);
    m_run = 1; m_cnt = 0; m_step = 0; m_wrap = 0;
    @(negedge clk_i);
    check_outs("R2");
  endtask

  task automatic stop_run();
    run_i = 1'b0;
    @(posedge clk_i);
    m_run = 0; m_step = 0; m_wrap = 0;
    @(negedge clk_i);
    check_outs("R11");
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 pwm", 32'(pwm_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk: R3, R4, R6, R7, R8
    foreach (VEC[v]) begin
      for (int s = 0; s < 4; s++) wr(s, VEC[v][s]);
      start_run();
      step_n("R3/R4/R7/R8", 2 * (VEC[v][0] + 1) + 1);
      stop_run();
    end

    // R5: buffered writes while running, applied at wrap
    wr(0, 5); wr(1, 2); wr(2, 3); wr(3, 4);
    start_run();
    step_n("R5", 2);
    wr(1, 5);
    wr(0, 3);
    chk("R5 pwm held", 32'(pwm_o), 32'b110);
    step_n("R5", 12);
    stop_run();

    // R11: strobes ignored while stopped
    step_n("R11", 5);

    // R10: wrong mode acts as stopped
    mode_i = 3'b010;
    run_i = 1'b1;
    step_n("R10", 5);
    run_i = 1'b0;
    mode_i = 3'b100;
    @(negedge clk_i);

    // R9: event-driven counting, strobe ignored
    wr(0, 1); wr(1, 1); wr(2, 2); wr(3, 0);
    ext_sel_i = 1'b1;
    start_run();
    cnt_tick_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R9 strobe ignored pwm", 32'(pwm_o), 32'b011);
    chk("R9 strobe ignored irq", 32'(irq_o), 0);
    evt_i = 1'b1;
    @(negedge clk_i);
    chk("R9 edge1", 32'(pwm_o), 32'b011);
    @(negedge clk_i);
    chk("R9 edge2", 32'(pwm_o), 32'b011);
    @(negedge clk_i);
    chk("R9 edge3 pwm", 32'(pwm_o), 32'b010);
    chk("R9 edge3 irq", 32'(irq_o), 32'b0010);
    repeat (3) @(negedge clk_i);
    chk("R9 level held no step", 32'(pwm_o), 32'b010);
    evt_i = 1'b0;
    cnt_tick_i = 1'b0;
    ext_sel_i = 1'b0;
    run_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R11 stopped pwm", 32'(pwm_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule